// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps time of day and calendar date as packed BCD counters and presents them to a processor as eight byte locations at the very top of a 13-bit byte address space. A prescaler divides an incoming oscillator tick down to one pulse per second. That pulse advances seconds, minutes, hours, day of week, date, month and year, with the full carry chain and month-length rules.

Software never touches the running counters directly. It reads and writes a bank of shadow bytes. After every second the shadow bytes are refreshed from the counters. A control byte can stop this refresh, so that a multi-byte read stays coherent. It can also open the shadow bytes for writing. Closing that write window copies the shadow bytes into the counters and restarts the prescaler.

A power-fail input locks out every bus write while it is high.

Top module: `rtc_shadow_bank`

## Requirements
- R1: Only byte addresses 1FF8h to 1FFFh are decoded. 1FF8h is the control byte. Then, in rising address order, come seconds, minutes, hours, day of week, date, month and year. A read of any other address returns 00h, and a write to any other address changes nothing.
- R2: After reset the control byte reads 00h and the time reads 00:00:00. Day of week, date and month read 01, and year reads 00.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into both the day of week and the date.
- R4: Day of week counts 1 to 7 and wraps from 7 back to 1.
- R5: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other long months. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00.
- R6: February ends on 29 when the year value is divisible by 4, and on 28 otherwise.
- R7: Every TICKS_PER_SEC oscillator ticks the counters advance by one second. The shadow bytes then take the new counter values, unless the freeze bit or the write bit is set.
- R8: While control bit 6 (freeze) is set, the shadow bytes keep their values and the counters keep running. The next refresh after the bit clears shows the elapsed time.
- R9: Writes to the time bytes land only while control bit 7 (write-open) is set. A control write that clears bit 7 while it was set loads all seven shadow bytes into the counters and restarts the prescaler from zero.
- R10: While pwr_fail is high, bus writes change neither the control byte nor any shadow byte.
- R11: Control bits 5:0 are stored and read back, and they have no effect on timekeeping.
- R12: A non-BCD byte is stored exactly as written. A field at or above its last legal value wraps to its first value and carries. Any other field increments its low digit, and a low digit of 9 or more clears to 0 and carries into the high digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse from the timebase, TICKS_PER_SEC per second |
| pwr_fail | input | 1 | High while the supply is out of tolerance; blocks all writes |
| bus_en | input | 1 | Bus access enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 00h when not addressed |

## Verification
The calendar is driven from random legal dates and times. About half of these starting points sit at 23:59:59, so that random month and year values reach the day, month and year carries. The other half are unbiased, which tests that a single second touches no other field. Directed starting points sit on each boundary of the month-length rule: Feb 28 in a leap year and in a common year, Feb 29, Apr 30, and Dec 31 23:59:59 of year 99. These separate the leap rule from the plain 28-day rule and the 30-day rule from the 31-day rule. Stray ticks before a load show whether the prescaler restarts. A stored non-BCD second shows the digit-carry rule.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helper functions for the calendar clock bank.
// Assumes packed BCD bytes; nothing here holds state.
package rtc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] bcd_t;

    // Seconds sit in the low byte so byte n of the flat vector matches offset n+1.
    typedef struct packed {
        bcd_t year;
        bcd_t month;
        bcd_t date;
        bcd_t day;
        bcd_t hour;
        bcd_t min;
        bcd_t sec;
    } rtc_time_t;

    localparam int   FIELDS     = 7;
    localparam bcd_t SEC_LAST   = 8'h59;
    localparam bcd_t HOUR_LAST  = 8'h23;
    localparam bcd_t DAY_LAST   = 8'h07;
    localparam bcd_t MONTH_LAST = 8'h12;
    localparam bcd_t YEAR_LAST  = 8'h99;
    localparam bcd_t ONE        = 8'h01;

    localparam rtc_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                         day: 8'h01, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    // Add one with a decimal carry out of the low digit.
    function automatic bcd_t bcd_next(input bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Leap test on a two-digit BCD year: 10 is congruent to 2 mod 4.
    function automatic logic is_leap(input bcd_t yr);
        logic [5:0] s;
        s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    // Last date of a month for a given year.
    function automatic bcd_t month_end(input bcd_t mon, input bcd_t yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the oscillator tick down to a one-cycle pulse per second.
// Assumes TICKS_PER_SEC >= 2; restart forces the count back to zero.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    assign sec_pulse = osc_tick && (cnt == LAST) && !restart;

    // Count ticks, wrap at the last one, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)      cnt <= '0;
        else if (osc_tick)          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == '0); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick && !restart |=> $stable(cnt)); // R7
endmodule

// File: rtl/rtc_calendar.sv
// Live BCD time counters with the full carry chain and month-length rules.
// Assumes advance is a one-cycle pulse; load overrides advance.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      advance,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    rtc_time_t nxt;
    logic c_min, c_hour, c_day, c_mon, c_year;

    // Next-second value: each field wraps at or above its last value and carries.
    always_comb begin
        nxt    = now;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        if (advance) begin
            if (now.sec >= SEC_LAST) begin nxt.sec = 8'h00; c_min = 1'b1; end
            else nxt.sec = bcd_next(now.sec);
        end
        if (c_min) begin
            if (now.min >= SEC_LAST) begin nxt.min = 8'h00; c_hour = 1'b1; end
            else nxt.min = bcd_next(now.min);
        end
        if (c_hour) begin
            if (now.hour >= HOUR_LAST) begin nxt.hour = 8'h00; c_day = 1'b1; end
            else nxt.hour = bcd_next(now.hour);
        end
        if (c_day) begin
            nxt.day = (now.day >= DAY_LAST) ? ONE : bcd_next(now.day);
            if (now.date >= month_end(now.month, now.year)) begin
                nxt.date = ONE;
                c_mon    = 1'b1;
            end else nxt.date = bcd_next(now.date);
        end
        if (c_mon) begin
            if (now.month >= MONTH_LAST) begin nxt.month = ONE; c_year = 1'b1; end
            else nxt.month = bcd_next(now.month);
        end
        if (c_year) nxt.year = (now.year >= YEAR_LAST) ? 8'h00 : bcd_next(now.year);
    end

    // Hold the live counters: reset, load from shadows, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)    now <= RESET_TIME;
        else if (load) now <= load_val;
        else           now <= nxt;
    end

    AST_HOLD_NO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        !advance && !load |=> $stable(now)); // R7
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> now == $past(load_val)); // R9
endmodule

// File: rtl/rtc_regs.sv
// Bus decode, control byte and the seven shadow bytes.
// Assumes a single-cycle write strobe; reads are taken by the top level.
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  rtc_time_t         live,
    input  logic              refresh,
    output logic              hit,
    output logic [2:0]        idx,
    output logic [BYTE_W-1:0] ctrl,
    output rtc_time_t         shadow,
    output logic              load
);
    localparam int FREEZE_BIT = 6;
    localparam int OPEN_BIT   = 7;

    logic we, ctrl_we, sh_we, refresh_ok;
    logic [FIELDS*BYTE_W-1:0] live_flat, sh_flat;

    assign hit        = &bus_addr[ADDR_W-1:3];
    assign idx        = bus_addr[2:0];
    assign we         = bus_en && bus_wr && hit && !pwr_fail;
    assign ctrl_we    = we && (idx == 3'd0);
    assign sh_we      = we && (idx != 3'd0) && ctrl[OPEN_BIT];
    assign load       = ctrl_we && ctrl[OPEN_BIT] && !bus_wdata[OPEN_BIT];
    assign refresh_ok = refresh && !ctrl[FREEZE_BIT] && !ctrl[OPEN_BIT];
    assign live_flat  = live;
    assign shadow     = rtc_time_t'(sh_flat);

    // Control byte: written whole by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (ctrl_we) ctrl <= bus_wdata;
    end

    localparam logic [FIELDS*BYTE_W-1:0] RST_FLAT = RESET_TIME;

    for (genvar g = 0; g < FIELDS; g++) begin : g_shadow
        // One shadow byte: bus write while open, else per-second refresh.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_flat[g*BYTE_W +: BYTE_W] <= RST_FLAT[g*BYTE_W +: BYTE_W];
            else if (sh_we && (idx == 3'(g + 1)))
                sh_flat[g*BYTE_W +: BYTE_W] <= bus_wdata;
            else if (refresh_ok)
                sh_flat[g*BYTE_W +: BYTE_W] <= live_flat[g*BYTE_W +: BYTE_W];
        end
    end

    AST_PF_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> $stable(ctrl)); // R10
    AST_PF_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail && !refresh |=> $stable(sh_flat)); // R10
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[FREEZE_BIT] && !(bus_en && bus_wr) |=> $stable(sh_flat)); // R8
    AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[OPEN_BIT] && !refresh |=> $stable(sh_flat)); // R9
endmodule

// File: rtl/rtc_shadow_bank.sv
// Top level: prescaler, live calendar and bus-visible register bank.
// Assumes synchronous bus signals; read data is combinational.
module rtc_shadow_bank
    import rtc_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              pwr_fail,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic              sec_pulse, refresh_q, load, hit;
    logic [2:0]        idx;
    logic [BYTE_W-1:0] ctrl;
    rtc_time_t         now, shadow;
    logic [FIELDS*BYTE_W-1:0] sh_flat;

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .restart(load), .sec_pulse(sec_pulse)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .advance(sec_pulse),
        .load(load), .load_val(shadow), .now(now)
    );

    // Refresh one cycle after the counters step, so shadows see the new second.
    always_ff @(posedge clk) begin
        if (!rst_n) refresh_q <= 1'b0;
        else        refresh_q <= sec_pulse;
    end

    rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .live(now), .refresh(refresh_q),
        .hit(hit), .idx(idx), .ctrl(ctrl), .shadow(shadow), .load(load)
    );

    assign sh_flat = shadow;

    // Read mux: control at offset 0, shadow bytes above, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr && hit) begin
            if (idx == 3'd0) bus_rdata = ctrl;
            else             bus_rdata = sh_flat[(idx - 3'd1)*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: tb/rtc_shadow_bank_bench.sv
module rtc_shadow_bank_bench;
    localparam int TPS = 4;
    localparam logic [12:0] CTRL_A = 13'h1FF8;

    logic clk = 0, rst_n = 0, osc_tick = 0, pwr_fail = 0;
    logic bus_en = 0, bus_wr = 0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    int checks = 0, errors = 0;
    bit done = 0;
    int ms, mmi, mh, mdw, mdt, mmo, my;

    always #2.5 clk = ~clk;

    rtc_shadow_bank #(.ADDR_W(13), .TICKS_PER_SEC(TPS)) u_rtc_shadow_bank (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pwr_fail(pwr_fail),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        ms++;
        if (ms == 60) begin ms = 0; mmi++; end
        if (mmi == 60) begin mmi = 0; mh++; end
        if (mh == 24) begin
            mh = 0;
            mdw = (mdw == 7) ? 1 : mdw + 1;
            mdt++;
            if (mdt > days_in(mmo, my)) begin
                mdt = 1; mmo++;
                if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
            end
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) osc_tick = 1;
            @(negedge clk) osc_tick = 0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic seconds(input int n);
        ticks(n * TPS);
        repeat (n) model_step();
    endtask

    task automatic set_time(input int h, input int mi, input int s, input int dw,
                            input int dt, input int mo, input int y);
        wr(CTRL_A, 8'h80);
        wr(CTRL_A + 1, to_bcd(s));  wr(CTRL_A + 2, to_bcd(mi));
        wr(CTRL_A + 3, to_bcd(h));  wr(CTRL_A + 4, to_bcd(dw));
        wr(CTRL_A + 5, to_bcd(dt)); wr(CTRL_A + 6, to_bcd(mo));
        wr(CTRL_A + 7, to_bcd(y));
        wr(CTRL_A, 8'h00);
        ms = s; mmi = mi; mh = h; mdw = dw; mdt = dt; mmo = mo; my = y;
    endtask

    task automatic chk_time(input string req);
        logic [7:0] d;
        rd(CTRL_A + 1, d); chk({req, " sec"},   d, to_bcd(ms));
        rd(CTRL_A + 2, d); chk({req, " min"},   d, to_bcd(mmi));
        rd(CTRL_A + 3, d); chk({req, " hour"},  d, to_bcd(mh));
        rd(CTRL_A + 4, d); chk({req, " day"},   d, to_bcd(mdw));
        rd(CTRL_A + 5, d); chk({req, " date"},  d, to_bcd(mdt));
        rd(CTRL_A + 6, d); chk({req, " month"}, d, to_bcd(mmo));
        rd(CTRL_A + 7, d); chk({req, " year"},  d, to_bcd(my));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2: reset state
        rd(CTRL_A, d); chk("R2 ctrl", d, 8'h00);
        ms = 0; mmi = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; my = 0;
        chk_time("R2");

        // R1: outside the window reads zero, writes do nothing
        rd(13'h1FF7, d); chk("R1 read below window", d, 8'h00);
        rd(13'h0123, d); chk("R1 read low address", d, 8'h00);
        wr(13'h1FF0, 8'h80); wr(13'h0FF9, 8'h45);
        rd(CTRL_A, d); chk("R1 alias write ctrl", d, 8'h00);
        chk_time("R1");

        // R9: writes without the open bit are dropped
        wr(CTRL_A + 1, 8'h42);
        rd(CTRL_A + 1, d); chk("R9 closed write", d, 8'h00);

        // R3 R4 R5: new year's eve at year 99, Sunday wraps to 1
        set_time(23, 59, 59, 7, 31, 12, 99);
        chk_time("R9 load readback");
        seconds(1); chk_time("R3 R4 R5 year rollover");

        // R6: leap and common Februaries, R5 30-day month
        set_time(23, 59, 59, 3, 28, 2, 24); seconds(1); chk_time("R6 Feb28 leap");
        rd(CTRL_A + 5, d); chk("R6 date 29", d, 8'h29);
        seconds(86400 - 86400 + 0);
        set_time(23, 59, 59, 4, 29, 2, 24); seconds(1); chk_time("R6 Feb29 leap");
        set_time(23, 59, 59, 2, 28, 2, 23); seconds(1); chk_time("R6 Feb28 common");
        rd(CTRL_A + 6, d); chk("R6 march", d, 8'h03);
        set_time(23, 59, 59, 5, 30, 4, 10); seconds(1); chk_time("R5 Apr30");
        set_time(10, 59, 58, 5, 15, 7, 10); seconds(2); chk_time("R3 minute hour carry");

        // R9: prescaler restarts on load
        ticks(2);
        set_time(1, 2, 3, 4, 5, 6, 7);
        ticks(TPS - 2);
        rd(CTRL_A + 1, d); chk("R9 prescaler restart early", d, 8'h03);
        ticks(2); model_step();
        rd(CTRL_A + 1, d); chk("R9 prescaler restart on time", d, 8'h04);

        // R8: freeze holds shadows, counters keep going
        wr(CTRL_A, 8'h40);
        seconds(2);
        rd(CTRL_A + 1, d); chk("R8 frozen sec", d, 8'h04);
        wr(CTRL_A, 8'h00);
        seconds(1); chk_time("R8 after thaw");

        // R11: calibration bits stored, no effect
        wr(CTRL_A, 8'h2A);
        rd(CTRL_A, d); chk("R11 ctrl readback", d, 8'h2A);
        seconds(1); chk_time("R11 timing unchanged");
        wr(CTRL_A, 8'h00);

        // R10: power fail blocks control and shadow writes
        pwr_fail = 1;
        wr(CTRL_A, 8'h80);
        rd(CTRL_A, d); chk("R10 ctrl blocked", d, 8'h00);
        pwr_fail = 0;
        wr(CTRL_A, 8'h80);
        pwr_fail = 1;
        wr(CTRL_A + 1, 8'h33);
        rd(CTRL_A + 1, d); chk("R10 shadow blocked", d, to_bcd(ms));
        wr(CTRL_A, 8'h00);
        rd(CTRL_A, d); chk("R10 close blocked", d, 8'h80);
        pwr_fail = 0;
        wr(CTRL_A, 8'h00);
        seconds(1); chk_time("R10 time intact");

        // R12: non-BCD seconds stored as written, digit carry resumes
        wr(CTRL_A, 8'h80);
        wr(CTRL_A + 1, 8'h1A);
        rd(CTRL_A + 1, d); chk("R12 stored raw", d, 8'h1A);
        wr(CTRL_A, 8'h00);
        ticks(TPS);
        rd(CTRL_A + 1, d); chk("R12 digit carry", d, 8'h20);
        wr(CTRL_A, 8'h80);
        wr(CTRL_A + 1, 8'h5C);
        wr(CTRL_A, 8'h00);
        ticks(TPS);
        rd(CTRL_A + 1, d); chk("R12 wrap above last", d, 8'h00);
        rd(CTRL_A + 2, d); chk("R12 wrap carries", d, to_bcd((mmi + 1) % 60));

        // R7 R3 R5 R6: random starting points, half biased to 23:59:59
        for (int i = 0; i < 40; i++) begin
            int y, mo, dt, h, mi, s, n;
            y  = int'($urandom_range(99));
            mo = int'($urandom_range(12, 1));
            dt = ($urandom_range(1) == 1) ? days_in(mo, y)
                                          : int'($urandom_range(days_in(mo, y), 1));
            if ($urandom_range(1) == 1) begin h = 23; mi = 59; s = 59; end
            else begin
                h  = int'($urandom_range(23));
                mi = int'($urandom_range(59));
                s  = int'($urandom_range(59));
            end
            set_time(h, mi, s, int'($urandom_range(7, 1)), dt, mo, y);
            n = int'($urandom_range(3, 1));
            seconds(n);
            chk_time("R7 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule